// File: doc/BRIEF.md
# Programmable Interrupt Router and Prioritizer

This block gathers up to 64 level-sensitive interrupt requests from peripherals and folds them onto nine general-purpose priority levels, numbered 7 to 15. Each source has its own 4-bit routing field that firmware can program. After reset the fields hold a built-in spread of the sources over levels 7 to 13. Per-source enable, wake-enable and raw-status bits sit in pairs of 32-bit words. The two lowest-priority levels, 14 and 15, can also be raised from software.

Every cycle the block registers the most urgent pending level for the core. The most urgent level is the lowest number. The output carries that level's number and a valid flag. A separate wake line signals any request whose wake-enable bit is set, whatever its enable bit holds. Firmware reaches all state through a small synchronous write/read bus with a registered read port.

Top module: `irq_router_top`

## Requirements
- R1: After reset, irq_valid_o, irq_lvl_o and wake_o are 0, and the enable, wake-enable and software bits are all 0. The routing field of source s holds s mod 7. Fields are 4 bits wide, eight to a word. Source s sits at word address 8 + s/8, bits 4*(s mod 8) up.
- R2: A routing field value v from 0 to 8 sends its source to level 7 + v. Values 9 to 15 leave the source unrouted, so it raises no level.
- R3: A source raises its level only while its enable bit is 1. Enable words sit at addresses 0 and 1, and source s uses bit s mod 32 of word s/32.
- R4: When one or more levels are pending, irq_valid_o is 1 and irq_lvl_o carries the lowest pending level number. When no level is pending, both are 0.
- R5: A change on src_irq_i shows at the outputs exactly one clock edge later. A register write shows one edge after the edge that commits it.
- R6: A write to address 6 sets software bit 0 (level 14) and bit 1 (level 15) wherever the data bit is 1. A write to address 7 clears the bits whose data bit is 1. Zero data bits change nothing. Reading address 6 returns the bits in [1:0].
- R7: wake_o is registered and rises one edge after any source is asserted with its wake-enable bit set, whatever that source's enable bit holds. Wake-enable words sit at addresses 4 and 5, with the same bit layout as R3.
- R8: Reading address 2 or 3 returns the request lines as sampled at the previous edge, in the layout of R3. Writes to these addresses change nothing.
- R9: bus_rdata_o loads on each edge where bus_rd_i is 1 and holds its value otherwise. Address 7 and addresses 16 to 31 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq_i | input | 64 | Level-sensitive peripheral requests |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_valid_o | output | 1 | Some level is pending |
| irq_lvl_o | output | 4 | Number of the most urgent pending level |
| wake_o | output | 1 | A wake-enabled source is asserted |

## Verification
The properties assume that the request lines and bus signals are stable around each rising edge. They also assume that reset is applied before the first checked edge. The software-raise property further assumes that no second reset arrives within its two-cycle window. The bench drives every input one nanosecond after an edge and holds it through the next edge. It uses only the decoded addresses, apart from deliberate probes of the unused ones. Its random phase sweeps sparse request patterns, arbitrary routing codes (unrouted ones included) and interleaved set and clear writes of the software bits.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

   // decoded register kinds of the bus address space
   typedef enum logic [2:0] {
      RK_MASK  = 3'd0,
      RK_STAT  = 3'd1,
      RK_WEN   = 3'd2,
      RK_SWSET = 3'd3,
      RK_SWCLR = 3'd4,
      RK_ASG   = 3'd5,
      RK_NONE  = 3'd6
   } irq_reg_kind_e;

   // reset-time routing: spread sources round-robin over hardware levels
   function automatic int unsigned dflt_route(int unsigned src, int unsigned hw_lvls);
      return src % hw_lvls;
   endfunction

endpackage

// File: rtl/irq_regfile.sv
`timescale 1ns/1ps
module irq_regfile
   import irq_router_pkg::*;
#(
   parameter int unsigned N_SRC   = 64,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned SW_LVLS = 2,
   parameter int unsigned HW_LVLS = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SRC-1:0]           src_i,
   input  logic                       wr_i,
   input  logic                       rd_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [WORD_W-1:0]          wdata_i,
   output logic [WORD_W-1:0]          rdata_o,
   output logic [N_SRC-1:0]           mask_o,
   output logic [N_SRC-1:0]           wen_o,
   output logic [N_SRC-1:0]           stat_o,
   output logic [SW_LVLS-1:0]         sw_o,
   output logic [N_SRC*FIELD_W-1:0]   asg_o
);

   localparam int unsigned NW     = (N_SRC + WORD_W - 1) / WORD_W;
   localparam int unsigned FPW    = WORD_W / FIELD_W;
   localparam int unsigned AW     = (N_SRC + FPW - 1) / FPW;
   localparam int unsigned PAD    = NW * WORD_W;
   localparam int unsigned APAD   = AW * WORD_W;
   localparam int unsigned A_STAT = NW;
   localparam int unsigned A_WEN  = 2 * NW;
   localparam int unsigned A_SET  = 3 * NW;
   localparam int unsigned A_CLR  = 3 * NW + 1;
   localparam int unsigned A_ASG  = 3 * NW + 2;
   localparam int unsigned A_END  = A_ASG + AW;

   function automatic logic [APAD-1:0] asg_default();
      logic [APAD-1:0] v;
      v = '1;
      for (int s = 0; s < int'(N_SRC); s++)
         v[s*FIELD_W +: FIELD_W] = FIELD_W'(dflt_route(s, HW_LVLS));
      return v;
   endfunction

   localparam logic [APAD-1:0] ASG_RST = asg_default();

   logic [PAD-1:0]     mask_q;
   logic [PAD-1:0]     wen_q;
   logic [PAD-1:0]     stat_q;
   logic [APAD-1:0]    asg_q;
   logic [SW_LVLS-1:0] sw_q;

   irq_reg_kind_e kind;
   int unsigned   a;
   int unsigned   idx;
   logic [WORD_W-1:0] rd_word;

   // address decode
   always_comb begin
      kind = RK_NONE;
      idx  = 0;
      a    = 32'(addr_i);
      if (a < A_STAT) begin
         kind = RK_MASK;
         idx  = a;
      end else if (a < A_WEN) begin
         kind = RK_STAT;
         idx  = a - A_STAT;
      end else if (a < A_SET) begin
         kind = RK_WEN;
         idx  = a - A_WEN;
      end else if (a == A_SET) begin
         kind = RK_SWSET;
      end else if (a == A_CLR) begin
         kind = RK_SWCLR;
      end else if (a < A_END) begin
         kind = RK_ASG;
         idx  = a - A_ASG;
      end
   end

   // read mux
   always_comb begin
      case (kind)
         RK_MASK:  rd_word = mask_q[idx*WORD_W +: WORD_W];
         RK_STAT:  rd_word = stat_q[idx*WORD_W +: WORD_W];
         RK_WEN:   rd_word = wen_q[idx*WORD_W +: WORD_W];
         RK_SWSET: rd_word = WORD_W'(sw_q);
         RK_ASG:   rd_word = asg_q[idx*WORD_W +: WORD_W];
         default:  rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         wen_q   <= '0;
         stat_q  <= '0;
         sw_q    <= '0;
         asg_q   <= ASG_RST;
         rdata_o <= '0;
      end else begin
         stat_q <= PAD'(src_i);
         if (rd_i)
            rdata_o <= rd_word;
         if (wr_i) begin
            case (kind)
               RK_MASK:  mask_q[idx*WORD_W +: WORD_W] <= wdata_i;
               RK_WEN:   wen_q[idx*WORD_W +: WORD_W]  <= wdata_i;
               RK_SWSET: sw_q <= sw_q | wdata_i[SW_LVLS-1:0];
               RK_SWCLR: sw_q <= sw_q & ~wdata_i[SW_LVLS-1:0];
               RK_ASG:   asg_q[idx*WORD_W +: WORD_W]  <= wdata_i;
               default:  ;
            endcase
         end
      end
   end

   assign mask_o = mask_q[N_SRC-1:0];
   assign wen_o  = wen_q[N_SRC-1:0];
   assign stat_o = stat_q[N_SRC-1:0];
   assign sw_o   = sw_q;
   assign asg_o  = asg_q[N_SRC*FIELD_W-1:0];

endmodule

// File: rtl/irq_level_map.sv
`timescale 1ns/1ps
module irq_level_map #(
   parameter int unsigned N_SRC   = 64,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned SW_LVLS = 2
) (
   input  logic [N_SRC-1:0]         src_i,
   input  logic [N_SRC-1:0]         mask_i,
   input  logic [N_SRC*FIELD_W-1:0] asg_i,
   input  logic [SW_LVLS-1:0]       sw_i,
   output logic [NUM_LVL-1:0]       pend_o
);

   localparam int unsigned SW_FIRST = NUM_LVL - SW_LVLS;

   for (genvar l = 0; l < int'(NUM_LVL); l++) begin : g_lvl
      logic [N_SRC-1:0] hit;
      for (genvar s = 0; s < int'(N_SRC); s++) begin : g_src
         assign hit[s] = src_i[s] & mask_i[s] &
                         (asg_i[s*FIELD_W +: FIELD_W] == FIELD_W'(l));
      end
      if (l >= int'(SW_FIRST)) begin : g_sw
         assign pend_o[l] = (|hit) | sw_i[l - int'(SW_FIRST)];
      end else begin : g_hw
         assign pend_o[l] = |hit;
      end
   end

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
   parameter int unsigned NUM_LVL  = 9,
   parameter int unsigned LVL_BASE = 7,
   parameter int unsigned LVL_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] pend_i,
   output logic               valid_o,
   output logic [LVL_W-1:0]   lvl_o
);

   logic             any_c;
   logic [LVL_W-1:0] num_c;

   // scan from least to most urgent; last hit (lowest index) wins
   always_comb begin
      any_c = 1'b0;
      num_c = '0;
      for (int l = int'(NUM_LVL) - 1; l >= 0; l--) begin
         if (pend_i[l]) begin
            any_c = 1'b1;
            num_c = LVL_W'(l + int'(LVL_BASE));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         lvl_o   <= '0;
      end else begin
         valid_o <= any_c;
         lvl_o   <= num_c;
      end
   end

endmodule

// File: rtl/irq_router_top.sv
`timescale 1ns/1ps
module irq_router_top #(
   parameter int unsigned N_SRC    = 64,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned FIELD_W  = 4,
   parameter int unsigned NUM_LVL  = 9,
   parameter int unsigned LVL_BASE = 7,
   parameter int unsigned SW_LVLS  = 2,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned LVL_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_irq_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [WORD_W-1:0] bus_wdata_i,
   output logic [WORD_W-1:0] bus_rdata_o,
   output logic              irq_valid_o,
   output logic [LVL_W-1:0]  irq_lvl_o,
   output logic              wake_o
);

   localparam int unsigned HW_LVLS = NUM_LVL - SW_LVLS;
   localparam int unsigned NW      = (N_SRC + WORD_W - 1) / WORD_W;
   localparam int unsigned FPW     = WORD_W / FIELD_W;
   localparam int unsigned AW      = (N_SRC + FPW - 1) / FPW;
   localparam int unsigned N_ADDR  = 3 * NW + 2 + AW;

   // elaboration-time parameter checks
   if ((WORD_W % FIELD_W) != 0) begin : g_bad_field
      $error("routing fields must tile a bus word");
   end
   if ((1 << FIELD_W) < NUM_LVL) begin : g_bad_code
      $error("routing field too narrow for the level count");
   end
   if (SW_LVLS >= NUM_LVL || SW_LVLS > WORD_W) begin : g_bad_sw
      $error("software levels must leave hardware levels");
   end
   if ((1 << ADDR_W) < N_ADDR) begin : g_bad_addr
      $error("address bus too narrow for the register map");
   end
   if ((1 << LVL_W) <= (LVL_BASE + NUM_LVL - 1)) begin : g_bad_lvl
      $error("level output too narrow");
   end

   logic [N_SRC-1:0]         mask_vec;
   logic [N_SRC-1:0]         wen_vec;
   logic [N_SRC-1:0]         stat_vec;
   logic [SW_LVLS-1:0]       sw_vec;
   logic [N_SRC*FIELD_W-1:0] asg_vec;
   logic [NUM_LVL-1:0]       pend_vec;
   logic                     wake_q;

   irq_regfile #(
      .N_SRC(N_SRC), .WORD_W(WORD_W), .FIELD_W(FIELD_W),
      .ADDR_W(ADDR_W), .SW_LVLS(SW_LVLS), .HW_LVLS(HW_LVLS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .src_i(src_irq_i),
      .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
      .mask_o(mask_vec), .wen_o(wen_vec), .stat_o(stat_vec),
      .sw_o(sw_vec), .asg_o(asg_vec)
   );

   irq_level_map #(
      .N_SRC(N_SRC), .FIELD_W(FIELD_W), .NUM_LVL(NUM_LVL), .SW_LVLS(SW_LVLS)
   ) u_map (
      .src_i(src_irq_i), .mask_i(mask_vec), .asg_i(asg_vec),
      .sw_i(sw_vec), .pend_o(pend_vec)
   );

   irq_prio_enc #(
      .NUM_LVL(NUM_LVL), .LVL_BASE(LVL_BASE), .LVL_W(LVL_W)
   ) u_enc (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_vec),
      .valid_o(irq_valid_o), .lvl_o(irq_lvl_o)
   );

   // wake ignores the enable mask on purpose
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= |(src_irq_i & wen_vec);
   end

   assign wake_o = wake_q;

endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
   parameter int unsigned N_SRC    = 64,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned NUM_LVL  = 9,
   parameter int unsigned LVL_BASE = 7,
   parameter int unsigned SW_LVLS  = 2,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned LVL_W    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_SRC-1:0]   src_i,
   input logic [N_SRC-1:0]   mask_i,
   input logic [N_SRC-1:0]   wen_i,
   input logic [N_SRC-1:0]   stat_i,
   input logic [SW_LVLS-1:0] sw_i,
   input logic               wr_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic               set0_i,
   input logic               irq_valid_i,
   input logic [LVL_W-1:0]   irq_lvl_i,
   input logic               wake_i
);

   localparam int unsigned NW    = (N_SRC + WORD_W - 1) / WORD_W;
   localparam int unsigned A_SET = 3 * NW;
   localparam int unsigned LO    = LVL_BASE;
   localparam int unsigned HI    = LVL_BASE + NUM_LVL - 1;
   localparam int unsigned SW_LO = LVL_BASE + NUM_LVL - SW_LVLS;

   // R1: reset holds the outputs quiet
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!irq_valid_i && !wake_i));

   // R4: reported level lies inside the level range, zero when idle
   p_lvl_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_i |-> (irq_lvl_i >= LVL_W'(LO) && irq_lvl_i <= LVL_W'(HI)));

   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid_i |-> (irq_lvl_i == '0));

   // R3: nothing enabled and no software bit -> no request next cycle
   p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (((src_i & mask_i) == '0) && (sw_i == '0)) |=> !irq_valid_i);

   // R6: raising the first software level yields a request at or above it
   p_sw_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (32'(addr_i) == A_SET) && set0_i) |-> ##2
         (irq_valid_i && irq_lvl_i <= LVL_W'(SW_LO)));

   // R7: wake follows wake-enabled requests, mask ignored
   p_wake_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_i & wen_i) != '0) |=> wake_i);

   p_wake_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_i & wen_i) == '0) |=> !wake_i);

   // R8: status mirrors the request lines one cycle late
   p_status_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (stat_i == $past(src_i)));

endmodule

bind irq_router_top irq_router_chk #(
   .N_SRC(N_SRC), .WORD_W(WORD_W), .NUM_LVL(NUM_LVL), .LVL_BASE(LVL_BASE),
   .SW_LVLS(SW_LVLS), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_i(src_irq_i), .mask_i(mask_vec),
   .wen_i(wen_vec), .stat_i(stat_vec), .sw_i(sw_vec), .wr_i(bus_wr_i),
   .addr_i(bus_addr_i), .set0_i(bus_wdata_i[0]), .irq_valid_i(irq_valid_o),
   .irq_lvl_i(irq_lvl_o), .wake_i(wake_o)
);

// File: tb/irq_router_top_tb_top.sv
`timescale 1ns/1ps
module irq_router_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_v = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_valid;
   logic [3:0]  irq_lvl;
   logic        wake;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // shadow of the programmed state
   logic [63:0] m_mask = '0;
   logic [63:0] m_wen  = '0;
   logic [1:0]  m_sw   = '0;
   logic [3:0]  m_asg [64];

   always #2.5 clk = ~clk;

   irq_router_top dut_i (
      .clk(clk), .rst_n(rst_n), .src_irq_i(src_v),
      .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .irq_valid_o(irq_valid), .irq_lvl_o(irq_lvl), .wake_o(wake)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_out();
      logic [8:0] p;
      logic [4:0] r;
      p = '0;
      r = '0;
      for (int i = 0; i < 64; i++)
         if (src_v[i] && m_mask[i] && m_asg[i] <= 4'd8) p[m_asg[i]] = 1'b1;
      p[7] = p[7] | m_sw[0];
      p[8] = p[8] | m_sw[1];
      for (int l = 8; l >= 0; l--)
         if (p[l]) r = {1'b1, 4'(l + 7)};
      return r;
   endfunction

   function automatic logic [31:0] exp_read(int a);
      logic [31:0] r;
      r = '0;
      case (a)
         0: r = m_mask[31:0];
         1: r = m_mask[63:32];
         2: r = src_v[31:0];
         3: r = src_v[63:32];
         4: r = m_wen[31:0];
         5: r = m_wen[63:32];
         6: r = {30'd0, m_sw};
         default: if (a >= 8 && a < 16)
            for (int k = 0; k < 8; k++) r[4*k +: 4] = m_asg[(a-8)*8 + k];
      endcase
      return r;
   endfunction

   task automatic check_out(input string req);
      chk(req, {27'd0, irq_valid, irq_lvl}, {27'd0, exp_out()});
      chk({req, " wake"}, {31'd0, wake}, {31'd0, |(src_v & m_wen)});
   endtask

   task automatic bwrite(input int a, input logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = 5'(a);
      bus_wdata = d;
      step();
      bus_wr = 1'b0;
      case (a)
         0: m_mask[31:0]  = d;
         1: m_mask[63:32] = d;
         4: m_wen[31:0]   = d;
         5: m_wen[63:32]  = d;
         6: m_sw = m_sw | d[1:0];
         7: m_sw = m_sw & ~d[1:0];
         default: if (a >= 8 && a < 16)
            for (int k = 0; k < 8; k++) m_asg[(a-8)*8 + k] = d[4*k +: 4];
      endcase
   endtask

   task automatic bread_chk(input string req, input int a);
      logic [31:0] e;
      e = exp_read(a);
      bus_rd = 1'b1;
      bus_addr = 5'(a);
      step();
      bus_rd = 1'b0;
      chk(req, bus_rdata, e);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] keep;
      void'($urandom(32'h5eed_1a7e));
      for (int s = 0; s < 64; s++) m_asg[s] = 4'(s % 7);

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();

      // R1: idle outputs and reset register contents
      check_out("R1 reset outputs");
      bread_chk("R1 reset enable word", 0);
      bread_chk("R1 reset wake-enable word", 5);
      bread_chk("R1 reset software bits", 6);
      for (int a = 8; a < 16; a++) bread_chk("R1 reset routing word", a);

      // R5: enable everything, one source, output moves one edge later
      bwrite(0, 32'hffff_ffff);
      bwrite(1, 32'hffff_ffff);
      step();
      src_v = 64'h8;
      #1 chk("R5 no change before edge", {31'd0, irq_valid}, 32'd0);
      step();
      check_out("R5 source 3 at level 10");

      // R4: two sources, lower level number wins
      src_v = 64'h208;
      step();
      check_out("R4 level 9 beats 10");
      src_v = 64'h4000_0000_0010_0000;
      step();
      check_out("R4 level 13 pair");

      // R2: re-route source 0 to code 8 then to unrouted code 9
      bwrite(8, (exp_read(8) & 32'hffff_fff0) | 32'h8);
      src_v = 64'h1;
      step();
      check_out("R2 code 8 to level 15");
      chk("R2 level 15 value", {28'd0, irq_lvl}, 32'd15);
      bwrite(8, (exp_read(8) & 32'hffff_fff0) | 32'h9);
      step();
      check_out("R2 code 9 unrouted");

      // R3: masked source stays silent
      src_v = 64'h8;
      bwrite(0, 32'h0);
      step();
      check_out("R3 masked source");
      chk("R3 no request", {31'd0, irq_valid}, 32'd0);

      // R6: software levels
      src_v = '0;
      bwrite(6, 32'h3);
      step();
      check_out("R6 both raised gives 14");
      bwrite(7, 32'h1);
      step();
      check_out("R6 clear 14 leaves 15");
      bwrite(6, 32'h0);
      step();
      check_out("R6 zero write no effect");
      bread_chk("R6 read software bits", 6);
      bwrite(7, 32'h2);
      step();
      check_out("R6 all cleared");

      // R7: wake despite mask bit 0
      bwrite(4, 32'h20);
      src_v = 64'h20;
      step();
      check_out("R7 wake with masked source");
      chk("R7 wake high", {31'd0, wake}, 32'd1);

      // R8: status readback and ignored write
      src_v = 64'h1234_5678_9abc_def0;
      step();
      bread_chk("R8 status low word", 2);
      bread_chk("R8 status high word", 3);
      bwrite(2, 32'h0);
      bread_chk("R8 status after write", 2);

      // R9: unused addresses and hold
      bread_chk("R9 address 7 reads 0", 7);
      bread_chk("R9 address 20 reads 0", 20);
      bread_chk("R9 load before hold", 0);
      keep = bus_rdata;
      bus_addr = 5'd4;
      step();
      chk("R9 hold without read", bus_rdata, keep);

      // random phase
      for (int it = 0; it < 600; it++) begin
         int op;
         op = int'($urandom_range(0, 7));
         case (op)
            0, 1, 2: src_v = {$urandom & $urandom & $urandom,
                              $urandom & $urandom & $urandom};
            3: bwrite(int'($urandom_range(0, 1)), $urandom | $urandom);
            4: bwrite(int'($urandom_range(4, 5)), $urandom & $urandom);
            5: bwrite(int'($urandom_range(8, 15)), $urandom);
            6: bwrite(int'($urandom_range(6, 7)), $urandom);
            default: bread_chk("R9 random readback", int'($urandom_range(0, 31)));
         endcase
         step();
         check_out("R4 random priority");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule